// File: doc/BRIEF.md
# Memory Clock Divider and Refresh Timer

This block produces the timing base for a DRAM controller from the core clock. It does not make a second clock. It produces a one-cycle enable pulse once per memory-clock period, and a phase level that marks the first half of that period. The period is an integer number of core cycles, set by a programmed ratio. The ratio is first forced into the supported range. An option input can also rule out one ratio value.

The enable pulses drive a fixed divide-by-16 prescaler. Each prescaler output advances a refresh down-counter, which is loaded with a programmed value equal to the wanted interval minus one. When that counter expires, a sticky refresh request is raised for the command scheduler. The request stays raised until the scheduler acknowledges it. If another expiry happens while a request is still waiting, the block counts it in a small saturating backlog, so no refresh obligation is lost unless the backlog is full.

Top module: `memclk_refresh_gen`

## Requirements
- R1: The programmed ratio `ratio_cfg` (4 bits, unsigned) is clamped before use. Values 0 to 3 act as 4, values 10 to 15 act as 9, and values 4 to 9 are used as given.
- R2: While `ratio5_block` is 1, a clamped ratio of 5 is used as 6. While it is 0, 5 is used as 5. Other values are not affected.
- R3: `mclk_en` is high for exactly one core cycle per period, in the last cycle of the period. Periods are R core cycles long, where R is the ratio in effect. The first period after reset uses the ratio sampled in the last reset cycle.
- R4: `mclk_phase` is high for the first floor(R/2) cycles of every period and low for the rest.
- R5: A new ratio is sampled only in the cycle where `mclk_en` is high, and it applies to the next period. A change in the middle of a period does not alter the current period.
- R6: A refresh expiry happens on the 16·(L+1)-th `mclk_en` pulse counted from reset or from the previous expiry. L is `refr_reload`, captured at reset and again at each expiry. `refr_req` is seen high in the cycle after the expiry.
- R7: `refr_req` stays high until `refr_ack` is sampled high. An acknowledge with an empty backlog clears the request on the next cycle.
- R8: An expiry while `refr_req` is high and `refr_ack` is low increments `refr_backlog`, which saturates at 7. An acknowledge with a nonzero backlog decrements it and keeps `refr_req` high. An expiry and an acknowledge in the same cycle leave both unchanged.
- R9: `refr_ack` while `refr_req` is low has no effect, and the next expiry still comes on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_cfg | input | 4 | Programmed core-to-memory clock ratio |
| ratio5_block | input | 1 | When 1, ratio 5 is replaced by 6 |
| refr_reload | input | 16 | Refresh interval in prescaled ticks, minus one |
| refr_ack | input | 1 | Refresh acknowledge from the command scheduler |
| mclk_en | output | 1 | One-cycle pulse at the end of each memory-clock period |
| mclk_phase | output | 1 | High during the first half of each period |
| refr_req | output | 1 | Sticky refresh request |
| refr_backlog | output | 3 | Expiries still waiting behind the current request |

## Verification
The assertions allow any value of `ratio_cfg`, `ratio5_block` and `refr_ack` in any cycle. The spacing and phase checks therefore hold under arbitrary reprogramming, not only under stable settings. The backlog saturation check is conditioned on acknowledge being low, because a concurrent acknowledge may lawfully decrement the count. The stimulus changes the ratio only at negative clock edges. It times its acknowledge bursts from an observed expiry, so that they fall well clear of the next expiry, except where the same-cycle case is meant.

// File: rtl/memclk_pkg.sv
package memclk_pkg;
  localparam int RATIO_W      = 4;
  localparam int RATIO_MIN    = 4;
  localparam int RATIO_MAX    = 9;
  localparam int RATIO_BANNED = 5;
  localparam int RATIO_BUMP   = 6;
  localparam int PRESCALE     = 16;
  localparam int REFR_W       = 16;
  localparam int PEND_W       = 3;
endpackage

// File: rtl/mclk_ratio_clamp.sv
module mclk_ratio_clamp
  import memclk_pkg::*;
#(
  parameter int W = RATIO_W
) (
  input  logic [W-1:0] cfg,
  input  logic         block5,
  output logic [W-1:0] ratio
);
  logic [W-1:0] ranged;

  always_comb begin
    if (cfg < W'(RATIO_MIN))      ranged = W'(RATIO_MIN);
    else if (cfg > W'(RATIO_MAX)) ranged = W'(RATIO_MAX);
    else                          ranged = cfg;
    if (block5 && ranged == W'(RATIO_BANNED)) ratio = W'(RATIO_BUMP);
    else                                      ratio = ranged;
  end
endmodule

// File: rtl/mclk_divider.sv
module mclk_divider #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ratio_in,
  output logic         tick_en,
  output logic         phase
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] ratio_q;
  logic [W-1:0] last_w;
  logic [W-1:0] half_w;

  assign last_w  = ratio_q - W'(1);
  assign half_w  = ratio_q >> 1;
  assign tick_en = (cnt_q == last_w);
  assign phase   = (cnt_q < half_w);

  // the ratio is shadowed so a new value only lands on a period boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= ratio_in;
    end else if (tick_en) begin
      cnt_q   <= '0;
      ratio_q <= ratio_in;
    end else begin
      cnt_q   <= cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/refr_interval_timer.sv
module refr_interval_timer #(
  parameter int REFR_W   = 16,
  parameter int PRESCALE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [REFR_W-1:0] reload,
  output logic              expire
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PRE_W-1:0]  pre_q;
  logic [REFR_W-1:0] cnt_q;
  logic              stage_tick;

  assign stage_tick = step_en && (pre_q == PRE_W'(PRESCALE - 1));
  assign expire     = stage_tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= reload;
    end else begin
      if (stage_tick)   pre_q <= '0;
      else if (step_en) pre_q <= pre_q + PRE_W'(1);
      if (stage_tick) begin
        if (cnt_q == '0) cnt_q <= reload;
        else             cnt_q <= cnt_q - REFR_W'(1);
      end
    end
  end
endmodule

// File: rtl/refr_req_tracker.sv
module refr_req_tracker #(
  parameter int PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              ack,
  output logic              req,
  output logic [PEND_W-1:0] backlog
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req     <= 1'b0;
      backlog <= '0;
    end else if (expire) begin
      if (!req) begin
        req <= 1'b1;
      end else if (!ack && backlog != '1) begin
        backlog <= backlog + PEND_W'(1);
      end
    end else if (ack && req) begin
      if (backlog != '0) backlog <= backlog - PEND_W'(1);
      else               req     <= 1'b0;
    end
  end
endmodule

// File: rtl/memclk_refresh_gen.sv
module memclk_refresh_gen
  import memclk_pkg::*;
#(
  parameter int RATIO_WD = RATIO_W,
  parameter int REFR_WD  = REFR_W,
  parameter int PEND_WD  = PEND_W,
  parameter int PRE_DIV  = PRESCALE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RATIO_WD-1:0] ratio_cfg,
  input  logic                ratio5_block,
  input  logic [REFR_WD-1:0]  refr_reload,
  input  logic                refr_ack,
  output logic                mclk_en,
  output logic                mclk_phase,
  output logic                refr_req,
  output logic [PEND_WD-1:0]  refr_backlog
);
  logic [RATIO_WD-1:0] ratio_eff;
  logic                expire;

  mclk_ratio_clamp #(.W(RATIO_WD)) u_clamp (
    .cfg    (ratio_cfg),
    .block5 (ratio5_block),
    .ratio  (ratio_eff)
  );

  mclk_divider #(.W(RATIO_WD)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .ratio_in (ratio_eff),
    .tick_en  (mclk_en),
    .phase    (mclk_phase)
  );

  refr_interval_timer #(.REFR_W(REFR_WD), .PRESCALE(PRE_DIV)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (mclk_en),
    .reload  (refr_reload),
    .expire  (expire)
  );

  refr_req_tracker #(.PEND_W(PEND_WD)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .ack     (refr_ack),
    .req     (refr_req),
    .backlog (refr_backlog)
  );
endmodule

// File: rtl/memclk_refresh_gen_chk.sv
module memclk_refresh_gen_chk #(
  parameter int PEND_WD = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ratio5_block,
  input logic               refr_ack,
  input logic               mclk_en,
  input logic               mclk_phase,
  input logic               refr_req,
  input logic [PEND_WD-1:0] refr_backlog
);
  logic [7:0] gap;
  logic       blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap   <= '0;
      blk_q <= ratio5_block;
    end else if (mclk_en) begin
      gap   <= '0;
      blk_q <= ratio5_block;
    end else if (gap != 8'hFF) begin
      gap   <= gap + 8'd1;
    end
  end

  // R1 R3: periods stay within 4..9 cycles
  p_en_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_en |-> (gap >= 8'd3 && gap <= 8'd8));

  p_no_ratio5_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_en && blk_q) |-> (gap != 8'd4));

  p_phase_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_en |=> mclk_phase);

  p_phase_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_en |-> !mclk_phase);

  p_req_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (refr_req && !refr_ack) |=> refr_req);

  p_backlog_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (refr_backlog != '0) |-> refr_req);

  p_backlog_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (refr_backlog == '1 && !refr_ack) |=> (refr_backlog == '1));
endmodule

bind memclk_refresh_gen memclk_refresh_gen_chk #(.PEND_WD(PEND_WD)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ratio5_block (ratio5_block),
  .refr_ack     (refr_ack),
  .mclk_en      (mclk_en),
  .mclk_phase   (mclk_phase),
  .refr_req     (refr_req),
  .refr_backlog (refr_backlog)
);

// File: tb/memclk_refresh_gen_tb_top.sv
module memclk_refresh_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ratio_cfg = 4'd4;
  logic        ratio5_block = 1'b0;
  logic [15:0] refr_reload = 16'd0;
  logic        refr_ack = 1'b0;
  logic        mclk_en, mclk_phase, refr_req;
  logic [2:0]  refr_backlog;

  int total = 0;
  int bad = 0;
  int en_acc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  memclk_refresh_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ratio_cfg(ratio_cfg), .ratio5_block(ratio5_block),
    .refr_reload(refr_reload), .refr_ack(refr_ack), .mclk_en(mclk_en),
    .mclk_phase(mclk_phase), .refr_req(refr_req), .refr_backlog(refr_backlog)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic step_cnt();
    @(negedge clk);
    if (mclk_en) en_acc++;
  endtask

  task automatic do_reset(input int ratio, input int reload);
    rst_n = 1'b0;
    ratio_cfg = 4'(ratio);
    refr_reload = 16'(reload);
    refr_ack = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    en_acc = 0;
  endtask

  task automatic sync_en();
    for (int i = 0; i < 20 && !mclk_en; i++) step();
  endtask

  task automatic measure(input string tag, input int exp_r);
    int n = 0;
    int ph = 0;
    sync_en();
    do begin
      step();
      n++;
      if (mclk_phase) ph++;
    end while (!mclk_en && n < 20);
    chk({tag, " period"}, n, exp_r);
    chk({"R4 phase width ", tag}, ph, exp_r / 2);
  endtask

  task automatic t_reset_state();
    do_reset(4, 0);
    chk("R3 reset en low", int'(mclk_en), 0);
    chk("R4 reset phase high", int'(mclk_phase), 1);
    chk("R7 reset req low", int'(refr_req), 0);
    chk("R8 reset backlog zero", int'(refr_backlog), 0);
    measure("R3 first period", 4);
  endtask

  task automatic t_clamp();
    ratio5_block = 1'b0;
    ratio_cfg = 4'd0;  sync_en(); measure("R1 cfg0", 4);
    ratio_cfg = 4'd2;  sync_en(); measure("R1 cfg2", 4);
    ratio_cfg = 4'd15; sync_en(); measure("R1 cfg15", 9);
    ratio_cfg = 4'd10; sync_en(); measure("R1 cfg10", 9);
    for (int r = 4; r <= 9; r++) begin
      ratio_cfg = 4'(r);
      sync_en();
      measure("R3 in range", r);
    end
  endtask

  task automatic t_ratio5();
    ratio5_block = 1'b0; ratio_cfg = 4'd5; sync_en(); measure("R2 five allowed", 5);
    ratio5_block = 1'b1; sync_en(); measure("R2 five bumped", 6);
    ratio_cfg = 4'd4; sync_en(); measure("R2 four untouched", 4);
    ratio5_block = 1'b0;
  endtask

  task automatic t_midchange();
    int n = 0;
    ratio_cfg = 4'd4;
    sync_en();
    measure("R5 base", 4);
    step();
    ratio_cfg = 4'd8;
    while (!mclk_en && n < 20) begin
      step();
      n++;
    end
    chk("R5 current period keeps old ratio", n + 1, 4);
    measure("R5 new ratio next period", 8);
  endtask

  task automatic t_refresh_period();
    int guard = 0;
    do_reset(6, 2);
    while (!refr_req && guard < 5000) begin
      step_cnt();
      guard++;
    end
    chk("R6 first expiry pulse count", en_acc, 48);
    repeat (10) step();
    chk("R7 request held without ack", int'(refr_req), 1);
    refr_ack = 1'b1; step(); refr_ack = 1'b0;
    chk("R7 ack clears request", int'(refr_req), 0);
    chk("R7 backlog stays zero", int'(refr_backlog), 0);
  endtask

  task automatic t_backlog();
    int guard = 0;
    do_reset(4, 0);
    while (refr_backlog != 3'd7 && guard < 5000) begin
      step();
      guard++;
    end
    chk("R8 backlog reaches seven", int'(refr_backlog), 7);
    chk("R8 request high with backlog", int'(refr_req), 1);
    en_acc = 0;
    while (en_acc < 16) step_cnt();
    step();
    chk("R8 backlog saturates", int'(refr_backlog), 7);
    en_acc = 0;
    for (int k = 6; k >= 0; k--) begin
      refr_ack = 1'b1; step_cnt(); refr_ack = 1'b0;
      chk("R8 ack decrements backlog", int'(refr_backlog), k);
      chk("R8 request kept while draining", int'(refr_req), 1);
    end
    refr_ack = 1'b1; step_cnt(); refr_ack = 1'b0;
    chk("R7 last ack clears request", int'(refr_req), 0);
    refr_ack = 1'b1; step_cnt(); refr_ack = 1'b0;
    chk("R9 idle ack no request", int'(refr_req), 0);
    chk("R9 idle ack no backlog", int'(refr_backlog), 0);
    guard = 0;
    while (!refr_req && guard < 2000) begin
      step_cnt();
      guard++;
    end
    chk("R9 next expiry on schedule", en_acc, 16);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step();
    t_reset_state();
    t_clamp();
    t_ratio5();
    t_midchange();
    t_refresh_period();
    t_backlog();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule